// File: doc/BRIEF.md
# Burst-Capable Processor Bus Master

This block is the master end of a 32-bit processor-style local bus. An internal requester hands it a single transfer or a four-beat line fill. The block starts each bus cycle by driving the word address, the active-low byte enables and the write/read cycle type. In that same clock it pulses an active-low address strobe. It then steps through the data phases as the system answers with one of two active-low handshakes: a single-transfer ready or a burst ready. An active-low last-transfer output tells the system which data phase will close the cycle, and it is driven for single cycles as well as bursts.

The system can pull an active-low back-off input at any time. Back-off takes priority over both readies. It releases the bus (the output-enable drops and the strobe and last-transfer go inactive), and once back-off is withdrawn the interrupted cycle starts again from its first beat. A separate active-low mask input forces byte-address bit 20 to zero on every address the block drives, so addresses wrap at 1 MiB.

The request side is a valid/ready stream. A request is taken on any clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle and back-off is not asserted, so a requester must hold its fields steady until that happens. The response side is a valid-only stream: it has no back-pressure, because the bus cannot be stalled once a ready has been returned. The consumer must therefore take every `resp_valid` pulse.

Top module: `bus_master_ctl`

## Requirements
- R1: `req_ready` is high only when no cycle is active and `boff_n` is high. A request taken at a clock edge raises the address strobe in the next clock.
- R2: `ads_n` is low for exactly one clock per cycle start. In that clock `bus_addr`, `bus_be_n`, `bus_wr` and (for writes) `bus_dout` carry the request.
- R3: In a single cycle `blast_n` is low from the strobe clock onward. In a burst `blast_n` is high for beats 0 to 2, including the strobe clock, and low during beat 3.
- R4: A burst read completes one beat on each sampled `brdy_n` low and ends after four beats. In beat k, `bus_addr[3:2]` is (start + k) mod 4 (with INTERLEAVE=1 it is start XOR k instead).
- R5: In a single cycle, either `rdy_n` or `brdy_n` low ends the cycle. In a burst, `rdy_n` low ends the cycle after that beat. After the cycle ends, `req_ready` is high again.
- R6: A ready sampled in the same clock as `boff_n` low is ignored: it produces no `resp_valid` and does not advance the beat.
- R7: From the clock after `boff_n` is sampled low until it is sampled high, `bus_oe` is 0, `ads_n` and `blast_n` are 1, and `req_ready` is 0.
- R8: After back-off ends, an interrupted cycle restarts. The strobe is pulsed again with the beat-0 address, and all beats are transferred anew.
- R9: While `a20_mask_n` is low, `bus_addr[20]` is 0. All other address bits are unchanged.
- R10: For a single cycle `bus_be_n` equals the inverse of the active-high `req_be` (bit i is byte lane i, data bits 8i+7:8i). For a burst all four `bus_be_n` bits are 0.
- R11: A write request is always a single cycle, and `req_burst` is ignored for writes. `bus_wr` is 1 for a write.
- R12: `resp_valid` pulses high for one clock in the clock after each accepted beat. `resp_data` holds the `bus_din` sampled for a read, and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Ask for a four-beat line fill (reads only) |
| req_addr | input | 30 | Word address, bits 31:2 |
| req_be | input | 4 | Active-high lane enables |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One pulse per completed beat |
| resp_data | output | 32 | Read data of that beat |
| a20_mask_n | input | 1 | Low forces address bit 20 to zero |
| bus_oe | output | 1 | Bus outputs driven (0 = floated) |
| bus_addr | output | 30 | Bus word address, bits 31:2 |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wr | output | 1 | Cycle type, 1 = write |
| ads_n | output | 1 | Active-low address strobe |
| blast_n | output | 1 | Active-low last-transfer |
| bus_dout | output | 32 | Write data to bus |
| bus_din | input | 32 | Read data from bus |
| rdy_n | input | 1 | Active-low single-transfer ready |
| brdy_n | input | 1 | Active-low burst ready |
| boff_n | input | 1 | Active-low back-off |

## Verification
The case that matters most is a burst ready and a back-off arriving in the same clock of a data phase. The bench provokes it by pulling `brdy_n` and `boff_n` low together during beat 0 of a line fill. In the clock that follows it expects no response pulse and a released bus with no strobe and no way to take a request. Once back-off is withdrawn, the bench requires a fresh strobe at the beat-0 address and then four complete beats, each with its own read data.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_BOFF = 2'd3
  } bus_st_e;
endpackage

// File: rtl/bmc_seq.sv
module bmc_seq
  import bmc_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_fire,
  input  logic          burst_q,
  input  logic          boff_n,
  input  logic          rdy_n,
  input  logic          brdy_n,
  output bus_st_e       st,
  output logic [BW-1:0] beat,
  output logic          beat_done,
  output logic          last_beat
);
  logic pend;
  logic cyc_end;

  // last beat of the cycle as announced on the bus
  assign last_beat = !burst_q || (beat == BW'(BEATS - 1));
  // a ready only counts in a data phase while back-off is idle
  assign beat_done = (st == ST_DATA) && boff_n && (!rdy_n || !brdy_n);
  // single ready in a burst ends it early
  assign cyc_end   = beat_done && (last_beat || !rdy_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      beat <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!boff_n) begin
            st   <= ST_BOFF;
            pend <= 1'b0;
          end else if (req_fire) begin
            st   <= ST_ADDR;
            beat <= '0;
          end
        end
        ST_ADDR: begin
          if (!boff_n) begin
            st   <= ST_BOFF;
            pend <= 1'b1;
          end else begin
            st <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (!boff_n) begin
            st   <= ST_BOFF;
            pend <= 1'b1;
          end else if (cyc_end) begin
            st <= ST_IDLE;
          end else if (beat_done) begin
            beat <= beat + 1'b1;
          end
        end
        default: begin
          beat <= '0;
          if (boff_n) st <= pend ? ST_ADDR : ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bmc_addr_gen.sv
module bmc_addr_gen #(
  parameter int AW         = 32,
  parameter int LB         = 2,
  parameter int BW         = 2,
  parameter int INTERLEAVE = 0,
  parameter int A20_BIT    = 20
) (
  input  logic [AW-1:LB] base,
  input  logic [BW-1:0]  beat,
  input  logic           a20_mask_n,
  output logic [AW-1:LB] addr
);
  logic [BW-1:0] sel;

  generate
    if (INTERLEAVE != 0) begin : g_xor
      assign sel = base[LB+BW-1:LB] ^ beat;
    end else begin : g_wrap
      assign sel = base[LB+BW-1:LB] + beat;
    end
  endgenerate

  always_comb begin
    addr = base;
    addr[LB+BW-1:LB] = sel;
    if (!a20_mask_n) addr[A20_BIT] = 1'b0;
  end
endmodule

// File: rtl/bmc_resp.sv
module bmc_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_done,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= beat_done;
      resp_data  <= (beat_done && !wr) ? din : '0;
    end
  end
endmodule

// File: rtl/bus_master_ctl.sv
module bus_master_ctl
  import bmc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BEATS      = 4,
  parameter int INTERLEAVE = 0,
  parameter int A20_BIT    = 20,
  localparam int LANES     = DW / 8,
  localparam int LB        = $clog2(LANES),
  localparam int BW        = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [AW-1:LB]   req_addr,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_data,
  input  logic             a20_mask_n,
  output logic             bus_oe,
  output logic [AW-1:LB]   bus_addr,
  output logic [LANES-1:0] bus_be_n,
  output logic             bus_wr,
  output logic             ads_n,
  output logic             blast_n,
  output logic [DW-1:0]    bus_dout,
  input  logic [DW-1:0]    bus_din,
  input  logic             rdy_n,
  input  logic             brdy_n,
  input  logic             boff_n
);
  bus_st_e          st;
  logic [BW-1:0]    beat;
  logic             beat_done;
  logic             last_beat;
  logic             req_fire;
  logic             wr_q;
  logic             burst_q;
  logic [AW-1:LB]   addr_q;
  logic [LANES-1:0] be_q;
  logic [DW-1:0]    wdata_q;
  logic             active;

  assign req_ready = (st == ST_IDLE) && boff_n;
  assign req_fire  = req_valid && req_ready;

  // request capture; a write never becomes a burst
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (req_fire) begin
      wr_q    <= req_write;
      burst_q <= req_burst && !req_write;
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  bmc_seq #(.BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .burst_q   (burst_q),
    .boff_n    (boff_n),
    .rdy_n     (rdy_n),
    .brdy_n    (brdy_n),
    .st        (st),
    .beat      (beat),
    .beat_done (beat_done),
    .last_beat (last_beat)
  );

  bmc_addr_gen #(
    .AW(AW), .LB(LB), .BW(BW), .INTERLEAVE(INTERLEAVE), .A20_BIT(A20_BIT)
  ) u_addr (
    .base       (addr_q),
    .beat       (beat),
    .a20_mask_n (a20_mask_n),
    .addr       (bus_addr)
  );

  bmc_resp #(.DW(DW)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_done  (beat_done),
    .wr         (wr_q),
    .din        (bus_din),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );

  assign active   = (st == ST_ADDR) || (st == ST_DATA);
  assign bus_oe   = (st != ST_BOFF);
  assign ads_n    = !(st == ST_ADDR);
  assign blast_n  = !(active && last_beat);
  assign bus_be_n = burst_q ? '0 : ~be_q;
  assign bus_wr   = wr_q;
  assign bus_dout = wdata_q;
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
  parameter int AW      = 32,
  parameter int LB      = 2,
  parameter int A20_BIT = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           ads_n,
  input logic           blast_n,
  input logic           bus_oe,
  input logic           boff_n,
  input logic           rdy_n,
  input logic           brdy_n,
  input logic           resp_valid,
  input logic           a20_mask_n,
  input logic [AW-1:LB] bus_addr
);
  // R1
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !ads_n);

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  // R7
  float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (ads_n && blast_n && !req_ready));

  // R9
  a20_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a20_mask_n |-> !bus_addr[A20_BIT]);

  // R6
  boff_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(boff_n));

  // R12
  resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(!rdy_n || !brdy_n));
endmodule

bind bus_master_ctl bmc_chk #(.AW(AW), .LB(LB), .A20_BIT(A20_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ads_n      (ads_n),
  .blast_n    (blast_n),
  .bus_oe     (bus_oe),
  .boff_n     (boff_n),
  .rdy_n      (rdy_n),
  .brdy_n     (brdy_n),
  .resp_valid (resp_valid),
  .a20_mask_n (a20_mask_n),
  .bus_addr   (bus_addr)
);

// File: tb/test_bus_master_ctl.sv
module test_bus_master_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [31:2] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        a20_mask_n = 1'b1;
  logic        bus_oe;
  logic [31:2] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_wr;
  logic        ads_n;
  logic        blast_n;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic        rdy_n = 1'b1;
  logic        brdy_n = 1'b1;
  logic        boff_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_master_ctl i_bus_master_ctl (.*);

  // {write, burst, word address, lane enables, beat that gets rdy_n (4 = none)}
  localparam int NV = 7;
  localparam logic [38:0] VECS [NV] = '{
    {1'b0, 1'b0, 30'h0400_0011, 4'b0011, 3'd0},
    {1'b0, 1'b0, 30'h0123_4566, 4'b1111, 3'd4},
    {1'b0, 1'b1, 30'h0000_0100, 4'b0001, 3'd4},
    {1'b0, 1'b1, 30'h0ABC_DEF2, 4'b1111, 3'd4},
    {1'b0, 1'b1, 30'h0000_0203, 4'b1111, 3'd1},
    {1'b1, 1'b1, 30'h0055_0009, 4'b0101, 3'd4},
    {1'b1, 1'b0, 30'h0300_000E, 4'b1000, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe clock then all data phases; entered one clock after acceptance
  task automatic phase(input logic [31:2] a, input logic wr, input logic burst,
                       input logic [3:0] be, input logic [31:0] wd, input int rdy_at,
                       input logic [31:0] dbase);
    logic eb;
    int n;
    logic [31:2] ea;
    eb = burst && !wr;
    n = !eb ? 1 : ((rdy_at < 4) ? rdy_at + 1 : 4);
    ea = a;
    if (!a20_mask_n) ea[20] = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 strobe", {31'd0, ads_n}, 32'd0);
    chk("R2/R9 address", {2'b0, bus_addr}, {2'b0, ea});
    chk("R11 cycle type", {31'd0, bus_wr}, {31'd0, wr});
    chk("R10 lanes", {28'd0, bus_be_n}, eb ? 32'd0 : {28'd0, ~be});
    chk("R3 last at strobe", {31'd0, blast_n}, eb ? 32'd1 : 32'd0);
    if (wr) chk("R2 write data", bus_dout, wd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ea[3:2] = a[3:2] + 2'(k);
      chk("R4 beat address", {2'b0, bus_addr}, {2'b0, ea});
      chk("R3 last", {31'd0, blast_n}, (!eb || k == 3) ? 32'd0 : 32'd1);
      chk("R2 strobe idle", {31'd0, ads_n}, 32'd1);
      if (k > 0) begin
        chk("R12 valid", {31'd0, resp_valid}, 32'd1);
        chk("R12 data", resp_data, dbase + 32'(k - 1));
      end
      bus_din = dbase + 32'(k);
      if ((eb && k == rdy_at) || (!eb && rdy_at == 0)) begin
        rdy_n = 1'b0; brdy_n = 1'b1;
      end else begin
        rdy_n = 1'b1; brdy_n = 1'b0;
      end
    end
    @(negedge clk);
    rdy_n = 1'b1; brdy_n = 1'b1;
    chk("R12 valid last", {31'd0, resp_valid}, 32'd1);
    chk("R12 data last", resp_data, wr ? 32'd0 : dbase + 32'(n - 1));
    chk("R5 cycle ended", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk("R12 no extra pulse", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic run_txn(input logic [31:2] a, input logic wr, input logic burst,
                         input logic [3:0] be, input int rdy_at, input logic [31:0] dbase);
    logic [31:0] wd;
    wd = 32'hA5A5_0000 ^ dbase;
    @(negedge clk);
    chk("R1 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_burst = burst;
    req_addr = a; req_be = be; req_wdata = wd;
    phase(a, wr, burst, be, wd, rdy_at, dbase);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:2] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R2 reset strobe", {31'd0, ads_n}, 32'd1);
    chk("R3 reset last", {31'd0, blast_n}, 32'd1);
    chk("R12 reset valid", {31'd0, resp_valid}, 32'd0);
    chk("R7 reset driven", {31'd0, bus_oe}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      run_txn(VECS[i][36:7], VECS[i][38], VECS[i][37], VECS[i][6:3],
              int'(VECS[i][2:0]), 32'hC0DE_0000 + 32'(i << 8));
    end

    // R9: mask forces bit 20 low on every beat of a burst
    a = '0; a[20] = 1'b1; a[12] = 1'b1; a[3:2] = 2'b01;
    a20_mask_n = 1'b0;
    run_txn(a, 1'b0, 1'b1, 4'hF, 4, 32'hBEEF_0000);
    a20_mask_n = 1'b1;
    run_txn(a, 1'b0, 1'b0, 4'h1, 0, 32'hBEEF_1000);

    // R6/R7/R8: back-off together with burst ready in beat 0
    a = 30'h0111_0002;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_burst = 1'b1; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 strobe before backoff", {31'd0, ads_n}, 32'd0);
    @(negedge clk);
    bus_din = 32'hDEAD_0000; brdy_n = 1'b0; boff_n = 1'b0;
    @(negedge clk);
    brdy_n = 1'b1;
    chk("R6 ready ignored", {31'd0, resp_valid}, 32'd0);
    chk("R7 floated", {31'd0, bus_oe}, 32'd0);
    chk("R7 strobe off", {31'd0, ads_n}, 32'd1);
    chk("R7 last off", {31'd0, blast_n}, 32'd1);
    chk("R7 no accept", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R7 still floated", {31'd0, bus_oe}, 32'd0);
    chk("R6 still no response", {31'd0, resp_valid}, 32'd0);
    boff_n = 1'b1;
    phase(a, 1'b0, 1'b1, 4'hF, 32'd0, 4, 32'h5EED_0000);
    chk("R8 driven again", {31'd0, bus_oe}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule